// File: doc/BRIEF.md
# Sync-Started Serial Descriptor Receiver

This block receives a bit-serial stream that carries no framing, and it starts only when an external sync input is asserted. While enabled, the receiver ignores every bit until the first sync. From then on it groups the incoming bits into characters of a programmable width, from 4 to 16 bits. Each finished character is stored as one 16-bit word in a local buffer RAM, which the host reads through a separate port.

Where each word goes is set by a ring of four receive descriptors. Each descriptor holds five fields:

- an empty (owned-by-receiver) flag
- an interrupt-enable flag
- a wrap flag
- a buffer start pointer
- a maximum length in characters

The receiver writes the running character count back into the active descriptor. When the count reaches the maximum, the receiver clears the empty flag, optionally pulses an interrupt, and moves to the next descriptor. If that descriptor is not empty, the receiver sets an overrun flag and throws characters away until the host rearms it.

The host programs a descriptor through a one-cycle write strobe. A write sets all fields and clears the count. Bits arrive one per clock, in the cycles where the bit strobe is high.

Top module: `sync_serial_rx`

## Requirements
- R1: While `en_i` is high, no bit is taken until `sync_i` is high. The bit sampled in the same cycle as `sync_i` is the first bit of the first character. Sync stays in effect until `en_i` falls.
- R2: Character n (counting from 0) of a descriptor is written to buffer address `ptr + n`. The descriptor's count field reads back the number of characters stored so far.
- R3: When a descriptor's count reaches its maximum length, its empty flag reads 0.
- R4: When a buffer fills and its interrupt flag is set, `irq_o` is high for exactly one clock cycle. When the interrupt flag is clear, `irq_o` stays low.
- R5: The character after a full buffer goes to the next descriptor if that descriptor's empty flag is 1. It is stored at that descriptor's pointer.
- R6: Character length follows `char_len_i` for values 4 to 16. Values below 4 act as 4, and values above 16 act as 16.
- R7: With `msb_first_i`=1, the first received bit lands in bit len-1 of the stored word. With `msb_first_i`=0, the first received bit lands in bit 0. Bits at len and above are 0.
- R8: A character that arrives while the current descriptor is not empty is discarded: there is no RAM write and the count does not change. It also sets `busy_o`, which stays set until `en_i` is low. Once the host rearms that descriptor, reception resumes into it.
- R9: After a full descriptor whose wrap flag is set, the next descriptor is entry 0. After entry 3, the next descriptor is always entry 0.
- R10: While `en_i` is low, the receiver drops any partial character, loses sync, returns to descriptor 0 and clears `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Receiver enable |
| sync_i | input | 1 | External sync, starts reception |
| bit_en_i | input | 1 | Serial bit valid this cycle |
| sdata_i | input | 1 | Serial data bit |
| char_len_i | input | 5 | Character length in bits |
| msb_first_i | input | 1 | 1: first bit is MSB of character |
| dsc_we_i | input | 1 | Descriptor write strobe |
| dsc_widx_i | input | 2 | Descriptor index to write |
| dsc_empty_i | input | 1 | Empty flag value to write |
| dsc_int_i | input | 1 | Interrupt flag value to write |
| dsc_wrap_i | input | 1 | Wrap flag value to write |
| dsc_ptr_i | input | 6 | Buffer start address to write |
| dsc_max_i | input | 6 | Maximum characters (1..63) to write |
| dsc_ridx_i | input | 2 | Descriptor index to read |
| dsc_empty_o | output | 1 | Empty flag of read descriptor |
| dsc_cnt_o | output | 6 | Character count of read descriptor |
| buf_raddr_i | input | 6 | Buffer RAM read address |
| buf_rdata_o | output | 16 | Buffer RAM read data |
| irq_o | output | 1 | Buffer-full interrupt pulse |
| busy_o | output | 1 | Overrun: character discarded |

## Verification
The checker tests these properties on every cycle:

- no character completes before a sync has been seen since enable
- characters are never on consecutive cycles
- every interrupt is a single cycle and follows an accepted buffer write
- the overrun flag never drops while the receiver is enabled

The bench scenarios are needed to show the rest. They cover the values stored for every length in both bit orders, the clamping of out-of-range lengths, chaining and wrap order across the ring, discard and resume after rearm, and the loss of a partial character on disable.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  parameter int unsigned NUM_DESC = 4;
  parameter int unsigned IDX_W    = $clog2(NUM_DESC);
  parameter int unsigned ADDR_W   = 6;
  parameter int unsigned LEN_W    = 6;
  parameter int unsigned WORD_W   = 16;
  parameter int unsigned CLEN_W   = $clog2(WORD_W + 1);
  parameter int unsigned MIN_CLEN = 4;

  typedef struct packed {
    logic              empty;
    logic              intr;
    logic              wrap;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  max_len;
    logic [LEN_W-1:0]  cnt;
  } rx_desc_t;
endpackage

// File: rtl/ssrx_char_asm.sv
module ssrx_char_asm
  import ssrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              bit_en_i,
  input  logic              sdata_i,
  input  logic [CLEN_W-1:0] char_len_i,
  input  logic              msb_first_i,
  output logic              char_vld_o,
  output logic [WORD_W-1:0] char_o
);
  localparam logic [CLEN_W-1:0] CLEN_MIN = CLEN_W'(MIN_CLEN);
  localparam logic [CLEN_W-1:0] CLEN_MAX = CLEN_W'(WORD_W);

  logic              synced_q;
  logic [CLEN_W-1:0] bit_cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [CLEN_W-1:0] clen;
  logic              take, last;
  logic [WORD_W-1:0] sh_nxt;

  always_comb begin
    if (char_len_i < CLEN_MIN)      clen = CLEN_MIN;
    else if (char_len_i > CLEN_MAX) clen = CLEN_MAX;
    else                            clen = char_len_i;
  end

  assign take = en_i & bit_en_i & (synced_q | sync_i);
  assign last = (bit_cnt_q == clen - CLEN_W'(1));

  // msb-first shifts up from zero; lsb-first drops the bit at its index
  always_comb begin
    if (msb_first_i) sh_nxt = {sh_q[WORD_W-2:0], sdata_i};
    else             sh_nxt = sh_q | (WORD_W'(sdata_i) << bit_cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q   <= 1'b0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      char_vld_o <= 1'b0;
      char_o     <= '0;
    end else if (!en_i) begin
      synced_q   <= 1'b0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      char_vld_o <= 1'b0;
    end else begin
      char_vld_o <= 1'b0;
      if (sync_i) synced_q <= 1'b1;
      if (take) begin
        if (last) begin
          char_o     <= sh_nxt;
          char_vld_o <= 1'b1;
          bit_cnt_q  <= '0;
          sh_q       <= '0;
        end else begin
          bit_cnt_q  <= bit_cnt_q + CLEN_W'(1);
          sh_q       <= sh_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/ssrx_desc_ring.sv
module ssrx_desc_ring
  import ssrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              char_vld_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_empty_i,
  input  logic              wr_int_i,
  input  logic              wr_wrap_i,
  input  logic [ADDR_W-1:0] wr_ptr_i,
  input  logic [LEN_W-1:0]  wr_max_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_empty_o,
  output logic [LEN_W-1:0]  rd_cnt_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic              irq_o,
  output logic              busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rx_desc_t         tbl_q [NUM_DESC];
  logic [IDX_W-1:0] cur_q;
  rx_desc_t         cur;
  logic             accept, full;
  logic [IDX_W-1:0] nxt_idx;

  assign cur         = tbl_q[cur_q];
  assign accept      = en_i & char_vld_i & cur.empty;
  assign full        = accept & ((cur.cnt + LEN_W'(1)) == cur.max_len);
  assign nxt_idx     = (cur.wrap || cur_q == LAST_IDX) ? '0 : cur_q + IDX_W'(1);
  assign ram_we_o    = accept;
  assign ram_waddr_o = cur.ptr + ADDR_W'(cur.cnt);
  assign rd_empty_o  = tbl_q[rd_idx_i].empty;
  assign rd_cnt_o    = tbl_q[rd_idx_i].cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DESC; i++) tbl_q[i] <= '0;
      cur_q  <= '0;
      irq_o  <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (!en_i) begin
        cur_q  <= '0;
        busy_o <= 1'b0;
      end else if (char_vld_i) begin
        if (!cur.empty) begin
          busy_o <= 1'b1;
        end else begin
          tbl_q[cur_q].cnt <= cur.cnt + LEN_W'(1);
          if (full) begin
            tbl_q[cur_q].empty <= 1'b0;
            irq_o              <= cur.intr;
            cur_q              <= nxt_idx;
          end
        end
      end
      // host write takes priority over a same-cycle update
      if (wr_en_i) begin
        tbl_q[wr_idx_i] <= '{empty: wr_empty_i, intr: wr_int_i, wrap: wr_wrap_i,
                             ptr: wr_ptr_i, max_len: wr_max_i, cnt: '0};
      end
    end
  end
endmodule

// File: rtl/ssrx_buf_ram.sv
module ssrx_buf_ram
  import ssrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              bit_en_i,
  input  logic              sdata_i,
  input  logic [CLEN_W-1:0] char_len_i,
  input  logic              msb_first_i,
  input  logic              dsc_we_i,
  input  logic [IDX_W-1:0]  dsc_widx_i,
  input  logic              dsc_empty_i,
  input  logic              dsc_int_i,
  input  logic              dsc_wrap_i,
  input  logic [ADDR_W-1:0] dsc_ptr_i,
  input  logic [LEN_W-1:0]  dsc_max_i,
  input  logic [IDX_W-1:0]  dsc_ridx_i,
  output logic              dsc_empty_o,
  output logic [LEN_W-1:0]  dsc_cnt_o,
  input  logic [ADDR_W-1:0] buf_raddr_i,
  output logic [WORD_W-1:0] buf_rdata_o,
  output logic              irq_o,
  output logic              busy_o
);
  logic              char_vld;
  logic [WORD_W-1:0] char_w;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;

  ssrx_char_asm u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .sync_i      (sync_i),
    .bit_en_i    (bit_en_i),
    .sdata_i     (sdata_i),
    .char_len_i  (char_len_i),
    .msb_first_i (msb_first_i),
    .char_vld_o  (char_vld),
    .char_o      (char_w)
  );

  ssrx_desc_ring u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .char_vld_i  (char_vld),
    .wr_en_i     (dsc_we_i),
    .wr_idx_i    (dsc_widx_i),
    .wr_empty_i  (dsc_empty_i),
    .wr_int_i    (dsc_int_i),
    .wr_wrap_i   (dsc_wrap_i),
    .wr_ptr_i    (dsc_ptr_i),
    .wr_max_i    (dsc_max_i),
    .rd_idx_i    (dsc_ridx_i),
    .rd_empty_o  (dsc_empty_o),
    .rd_cnt_o    (dsc_cnt_o),
    .ram_we_o    (ram_we),
    .ram_waddr_o (ram_waddr),
    .irq_o       (irq_o),
    .busy_o      (busy_o)
  );

  ssrx_buf_ram u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (char_w),
    .raddr_i (buf_raddr_i),
    .rdata_o (buf_rdata_o)
  );
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sync_i,
  input logic char_vld_i,
  input logic irq_i,
  input logic busy_i,
  input logic ram_we_i
);
  logic seen_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_sync_q <= 1'b0;
    else if (!en_i)          seen_sync_q <= 1'b0;
    else if (sync_i)         seen_sync_q <= 1'b1;
  end

  AST_NO_CHAR_BEFORE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i |-> seen_sync_q); // R1

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(ram_we_i)); // R3

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R4

  AST_CHAR_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i |=> !char_vld_i); // R6

  AST_BUSY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && en_i) |=> busy_i); // R8
endmodule

bind sync_serial_rx sync_serial_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .sync_i     (sync_i),
  .char_vld_i (char_vld),
  .irq_i      (irq_o),
  .busy_i     (busy_o),
  .ram_we_i   (ram_we)
);

// File: tb/sync_serial_rx_tb_top.sv
module sync_serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, sync = 1'b0, bit_en = 1'b0, sdata = 1'b0;
  logic [4:0]  char_len = 5'd8;
  logic        msb_first = 1'b0;
  logic        dsc_we = 1'b0;
  logic [1:0]  dsc_widx = '0, dsc_ridx = '0;
  logic        dsc_empty_w = 1'b0, dsc_int_w = 1'b0, dsc_wrap_w = 1'b0;
  logic [5:0]  dsc_ptr = '0, dsc_max = '0, buf_raddr = '0;
  logic        dsc_empty_r;
  logic [5:0]  dsc_cnt_r;
  logic [15:0] buf_rdata;
  logic        irq, busy;

  int n_chk = 0, n_err = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_serial_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_i(sync), .bit_en_i(bit_en),
    .sdata_i(sdata), .char_len_i(char_len), .msb_first_i(msb_first),
    .dsc_we_i(dsc_we), .dsc_widx_i(dsc_widx), .dsc_empty_i(dsc_empty_w),
    .dsc_int_i(dsc_int_w), .dsc_wrap_i(dsc_wrap_w), .dsc_ptr_i(dsc_ptr),
    .dsc_max_i(dsc_max), .dsc_ridx_i(dsc_ridx), .dsc_empty_o(dsc_empty_r),
    .dsc_cnt_o(dsc_cnt_r), .buf_raddr_i(buf_raddr), .buf_rdata_o(buf_rdata),
    .irq_o(irq), .busy_o(busy)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_word(input logic [15:0] v, input int len, input bit msb);
    logic [15:0] r = '0;
    for (int i = 0; i < len; i++) begin
      if (msb) r[len-1-i] = v[i];
      else     r[i] = v[i];
    end
    return int'(r);
  endfunction

  // bits go out v[0] first
  task automatic send(input logic [15:0] v, input int n, input bit first_sync);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata  = v[i];
      bit_en = 1'b1;
      sync   = first_sync && (i == 0);
    end
    @(negedge clk);
    bit_en = 1'b0;
    sync   = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_desc(input int idx, input bit e, input bit it, input bit w,
                         input int ptr, input int mx);
    @(negedge clk);
    dsc_we = 1'b1; dsc_widx = 2'(idx); dsc_empty_w = e; dsc_int_w = it;
    dsc_wrap_w = w; dsc_ptr = 6'(ptr); dsc_max = 6'(mx);
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  task automatic rd_buf(input int a, output int d);
    @(negedge clk);
    buf_raddr = 6'(a);
    #1 d = int'(buf_rdata);
  endtask

  task automatic rd_desc(input int idx, output int e, output int c);
    @(negedge clk);
    dsc_ridx = 2'(idx);
    #1;
    e = int'(dsc_empty_r);
    c = int'(dsc_cnt_r);
  endtask

  initial begin
    int e, c, d, irq0;
    logic [15:0] v;
    int exp_tab [26];
    int k;

    repeat (3) @(negedge clk);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_desc(i, e, c);
      chk("R3 reset empty", e, 0);
    end

    wr_desc(0, 1, 1, 0, 0, 26);
    wr_desc(1, 1, 0, 0, 32, 2);
    wr_desc(2, 1, 1, 1, 40, 1);
    wr_desc(3, 1, 0, 0, 41, 1);
    @(negedge clk); en = 1'b1;

    // R1: unsynced bits are ignored
    send(16'hBEEF, 16, 0);
    send(16'h1234, 12, 0);
    rd_desc(0, e, c);
    chk("R1 no capture before sync", c, 0);

    // R6/R7 sweep: every length, both orders
    k = 0;
    for (int len = 4; len <= 16; len++) begin
      for (int m = 0; m < 2; m++) begin
        v = 16'hA5C3 ^ 16'(len * 16'h1111) ^ (m != 0 ? 16'h5A5A : 16'h0);
        @(negedge clk);
        char_len = 5'(len); msb_first = m[0];
        exp_tab[k] = exp_word(v, len, m[0]);
        send(v, len, k == 0);
        k++;
      end
    end
    for (int i = 0; i < 26; i++) begin
      rd_buf(i, d);
      chk($sformatf("R7 R6 R2 word %0d", i), d, exp_tab[i]);
    end
    rd_desc(0, e, c);
    chk("R2 count writeback", c, 26);
    chk("R3 empty cleared", e, 0);
    chk("R4 irq on full", irq_cnt, 1);

    // R5 chain to desc1; R6 clamping
    @(negedge clk); msb_first = 1'b0; char_len = 5'd2;
    send(16'h000B, 4, 0);
    @(negedge clk); char_len = 5'd20;
    send(16'hC3A7, 16, 0);
    rd_buf(32, d); chk("R6 clamp low", d, 16'h000B);
    rd_buf(33, d); chk("R6 clamp high R5 chain", d, 16'hC3A7);
    rd_desc(1, e, c);
    chk("R5 desc1 count", c, 2);
    chk("R4 no irq when flag clear", irq_cnt, 1);

    // desc2 wraps to entry 0, which is full
    @(negedge clk); char_len = 5'd8;
    send(16'h005A, 8, 0);
    rd_buf(40, d); chk("R5 desc2 word", d, 16'h5A);
    chk("R4 irq desc2", irq_cnt, 2);
    send(16'h00E1, 8, 0);
    chk("R8 busy on overrun", int'(busy), 1);
    rd_desc(3, e, c); chk("R9 wrap skips desc3", c, 0);
    rd_desc(0, e, c); chk("R8 discarded count", c, 26);
    rd_buf(0, d); chk("R8 no overwrite", d, exp_tab[0]);

    // rearm and resume
    wr_desc(0, 1, 0, 0, 50, 2);
    send(16'h0077, 8, 0);
    rd_buf(50, d); chk("R8 resume after rearm", d, 16'h77);
    send(16'h0088, 8, 0);
    rd_buf(51, d); chk("R5 second word", d, 16'h88);
    chk("R8 busy sticky while enabled", int'(busy), 1);

    // R10: partial char dropped, index reset, sync lost
    send(16'h0007, 3, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R10 busy cleared", int'(busy), 0);
    wr_desc(0, 1, 1, 0, 60, 1);
    @(negedge clk); en = 1'b1;
    send(16'h0FFF, 12, 0);
    rd_desc(0, e, c); chk("R10 R1 sync lost", c, 0);
    irq0 = irq_cnt;
    send(16'h0096, 8, 1);
    rd_buf(60, d); chk("R10 partial dropped", d, 16'h96);
    chk("R10 back at desc0", int'(busy), 0);
    chk("R4 irq after reenable", irq_cnt, irq0 + 1);

    // R9: entry 3 without wrap returns to 0
    wr_desc(1, 1, 0, 0, 61, 1);
    wr_desc(2, 1, 0, 0, 62, 1);
    wr_desc(3, 1, 0, 0, 63, 1);
    wr_desc(0, 1, 0, 0, 59, 1);
    for (int i = 0; i < 4; i++) send(16'(16'h10 + i), 8, 0);
    rd_buf(61, d); chk("R9 order 1", d, 16'h10);
    rd_buf(62, d); chk("R9 order 2", d, 16'h11);
    rd_buf(63, d); chk("R9 order 3", d, 16'h12);
    rd_buf(59, d); chk("R9 last wraps to 0", d, 16'h13);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule